// File: doc/BRIEF.md
# Received Packet Payload Distributor

This block sits behind the receive side of a serial-bus link layer. It takes a decoded packet header (transaction code, transaction label, 48-bit destination offset) and then the packet's payload as a stream of 32-bit quadlets. It sorts each packet into one of seven fixed-size storage regions. One region is general receive storage. The other six serve a storage-transport protocol that fetches command blocks, pointers, page tables and bulk data from a remote initiator.

A write request is routed by its destination offset. Two fixed offsets mark the management and command agent pointer registers. A read response is routed by its transaction label. The label is looked up in a table of outstanding requests, and the kind recorded when that request was issued picks the region. A response whose label is not outstanding is discarded. Everything else goes to general storage. Each accepted quadlet leaves through a single registered write port that carries a region code and an address inside the region. When a packet ends, a sticky per-region interrupt bit is set for firmware.

Top module: `rx_payload_sorter`

## Requirements
- R1: There are seven regions, and `wr_region` encodes them as 0 management agent pointer, 1 command agent pointer, 2 management command block, 3 command block, 4 page table pointer, 5 general receive, 6 bulk data. No write ever carries code 7.
- R2: Region capacities in quadlets are 2 for each agent pointer, 8 for each command block, 2 for the page table pointer, 8 for general receive and 1024 for bulk data. `wr_addr` is always below the capacity of its region.
- R3: A write request (tcode 0 or 1) is routed by its offset. Offset `MGMT_AGT_OFS` goes to region 0, offset `CMD_AGT_OFS` goes to region 1, and any other offset goes to region 5.
- R4: A read response (tcode 6 or 7) whose label is outstanding goes to the region of the recorded request kind: kind 0 to region 2, kind 1 to region 3, kind 2 to region 4, kind 3 to region 6. The response consumes the table entry.
- R5: A read response never goes to region 5. A response whose label is not outstanding writes nothing, raises no interrupt and sets `unexp_flag` one cycle after its header.
- R6: Every other tcode, such as a read request (4 or 5), goes to region 5.
- R7: The quadlets of a packet are written in order at addresses 0, 1, 2 and so on. Each write appears on the port one cycle after its quadlet is presented.
- R8: Quadlets beyond the capacity of a region are not written, and `ovf_flag` is set.
- R9: When a packet completes, `irq` bit n (n = region code) is set one cycle after its last quadlet is presented, or one cycle after its header if `hdr_empty` is 1. The bit stays set until a 1 is written to the same bit of `irq_clr`. A set in the same cycle as a clear wins.
- R10: `flag_clr` bit 0 clears `ovf_flag` and bit 1 clears `unexp_flag`.
- R11: After reset, `irq`, both flags and `wr_en` are 0, and no label is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_issue | input | 1 | Records an outstanding read request |
| req_label | input | 6 | Label of the issued request |
| req_kind | input | 2 | Kind of the issued request (0..3, see R4) |
| hdr_valid | input | 1 | Header strobe, one cycle per packet |
| hdr_tcode | input | 4 | Transaction code |
| hdr_label | input | 6 | Transaction label |
| hdr_offset | input | 48 | Destination offset |
| hdr_empty | input | 1 | Packet carries no payload |
| pl_valid | input | 1 | Payload quadlet valid |
| pl_data | input | 32 | Payload quadlet |
| pl_last | input | 1 | Final quadlet of the packet |
| wr_en | output | 1 | Region write strobe |
| wr_region | output | 3 | Target region code |
| wr_addr | output | 10 | Quadlet address inside region |
| wr_data | output | 32 | Quadlet written |
| irq | output | 7 | Sticky per-region completion interrupts |
| irq_clr | input | 7 | Write-1-to-clear for `irq` |
| ovf_flag | output | 1 | Sticky overflow flag |
| unexp_flag | output | 1 | Sticky unexpected-response flag |
| flag_clr | input | 2 | Write-1-to-clear for the two flags |

## Verification
A quadlet presented before a clock edge shows up on the write port right after that edge. So does the interrupt for a final quadlet and the unexpected flag for an unmatched header. A clear input takes effect at the next edge. The bench drives every input on the falling edge and samples on a later falling edge. Expected writes go into a queue that a monitor drains on each falling edge. Interrupts, flags and an empty queue are checked at the falling edge one cycle after the packet ends, which leaves the monitor a full cycle to pop the last write.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [2:0] {
    RG_MAGT = 3'd0,
    RG_CAGT = 3'd1,
    RG_MORB = 3'd2,
    RG_CORB = 3'd3,
    RG_PTE  = 3'd4,
    RG_GEN  = 3'd5,
    RG_BULK = 3'd6,
    RG_DROP = 3'd7
  } region_e;

  typedef enum logic [1:0] {
    K_MORB = 2'd0,
    K_CORB = 2'd1,
    K_PTE  = 2'd2,
    K_BULK = 2'd3
  } req_kind_e;

  localparam int NUM_REGIONS = 7;
endpackage

// File: rtl/rps_rst_sync.sv
module rps_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/rps_label_table.sv
module rps_label_table
  import rps_pkg::*;
#(
  parameter int LABEL_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [LABEL_W-1:0] issue_label,
  input  req_kind_e          issue_kind,
  input  logic               look_en,
  input  logic [LABEL_W-1:0] look_label,
  output logic               hit,
  output req_kind_e          hit_kind
);
  localparam int ENTRIES = 1 << LABEL_W;

  logic [ENTRIES-1:0] vld_q;
  req_kind_e          kind_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic sel_issue, sel_look, vld_d;

    always_comb begin
      sel_issue = issue && (issue_label == LABEL_W'(i));
      sel_look  = look_en && (look_label == LABEL_W'(i));
      vld_d     = vld_q[i];
      if (sel_look)  vld_d = 1'b0;
      if (sel_issue) vld_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i]  <= 1'b0;
        kind_q[i] <= K_MORB;
      end else begin
        vld_q[i] <= vld_d;
        if (sel_issue) kind_q[i] <= issue_kind;
      end
    end
  end

  assign hit      = vld_q[look_label];
  assign hit_kind = kind_q[look_label];
endmodule

// File: rtl/rps_classify.sv
module rps_classify
  import rps_pkg::*;
#(
  parameter int               OFS_W        = 48,
  parameter logic [OFS_W-1:0] MGMT_AGT_OFS = 48'hFFFF_F001_0000,
  parameter logic [OFS_W-1:0] CMD_AGT_OFS  = 48'hFFFF_F001_0100
) (
  input  logic [3:0]       tcode,
  input  logic [OFS_W-1:0] offset,
  input  logic             hit,
  input  req_kind_e        hit_kind,
  output logic             is_resp,
  output logic             miss,
  output region_e          cls
);
  logic is_wr;

  always_comb begin
    is_resp = (tcode == 4'h6) || (tcode == 4'h7);
    is_wr   = (tcode == 4'h0) || (tcode == 4'h1);
    miss    = 1'b0;
    cls     = RG_GEN;
    if (is_resp) begin
      if (hit) begin
        unique case (hit_kind)
          K_MORB:  cls = RG_MORB;
          K_CORB:  cls = RG_CORB;
          K_PTE:   cls = RG_PTE;
          default: cls = RG_BULK;
        endcase
      end else begin
        cls  = RG_DROP;
        miss = 1'b1;
      end
    end else if (is_wr && offset == MGMT_AGT_OFS) begin
      cls = RG_MAGT;
    end else if (is_wr && offset == CMD_AGT_OFS) begin
      cls = RG_CAGT;
    end
  end
endmodule

// File: rtl/rx_payload_sorter.sv
module rx_payload_sorter
  import rps_pkg::*;
#(
  parameter int               LABEL_W      = 6,
  parameter int               OFS_W        = 48,
  parameter int               DATA_W       = 32,
  parameter int               AGT_QUADS    = 2,
  parameter int               ORB_QUADS    = 8,
  parameter int               PTE_QUADS    = 2,
  parameter int               GEN_QUADS    = 8,
  parameter int               BULK_QUADS   = 1024,
  parameter logic [OFS_W-1:0] MGMT_AGT_OFS = 48'hFFFF_F001_0000,
  parameter logic [OFS_W-1:0] CMD_AGT_OFS  = 48'hFFFF_F001_0100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_issue,
  input  logic [LABEL_W-1:0]            req_label,
  input  logic [1:0]                    req_kind,
  input  logic                          hdr_valid,
  input  logic [3:0]                    hdr_tcode,
  input  logic [LABEL_W-1:0]            hdr_label,
  input  logic [OFS_W-1:0]              hdr_offset,
  input  logic                          hdr_empty,
  input  logic                          pl_valid,
  input  logic [DATA_W-1:0]             pl_data,
  input  logic                          pl_last,
  output logic                          wr_en,
  output logic [2:0]                    wr_region,
  output logic [$clog2(BULK_QUADS)-1:0] wr_addr,
  output logic [DATA_W-1:0]             wr_data,
  output logic [NUM_REGIONS-1:0]        irq,
  input  logic [NUM_REGIONS-1:0]        irq_clr,
  output logic                          ovf_flag,
  output logic                          unexp_flag,
  input  logic [1:0]                    flag_clr
);
  localparam int CNT_W  = $clog2(BULK_QUADS + 1);
  localparam int ADDR_W = $clog2(BULK_QUADS);

  function automatic logic [CNT_W-1:0] cap_of(region_e r);
    case (r)
      RG_MAGT, RG_CAGT: cap_of = CNT_W'(AGT_QUADS);
      RG_MORB, RG_CORB: cap_of = CNT_W'(ORB_QUADS);
      RG_PTE:           cap_of = CNT_W'(PTE_QUADS);
      RG_GEN:           cap_of = CNT_W'(GEN_QUADS);
      RG_BULK:          cap_of = CNT_W'(BULK_QUADS);
      default:          cap_of = '0;
    endcase
  endfunction

  logic      rst_s_n;
  logic      hit, is_resp, miss;
  req_kind_e hit_kind;
  region_e   hdr_cls;

  rps_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_s_n));

  rps_label_table #(.LABEL_W(LABEL_W)) u_tbl (
    .clk(clk), .rst_n(rst_s_n),
    .issue(req_issue), .issue_label(req_label), .issue_kind(req_kind_e'(req_kind)),
    .look_en(hdr_valid && is_resp), .look_label(hdr_label),
    .hit(hit), .hit_kind(hit_kind)
  );

  rps_classify #(.OFS_W(OFS_W), .MGMT_AGT_OFS(MGMT_AGT_OFS), .CMD_AGT_OFS(CMD_AGT_OFS)) u_cls (
    .tcode(hdr_tcode), .offset(hdr_offset), .hit(hit), .hit_kind(hit_kind),
    .is_resp(is_resp), .miss(miss), .cls(hdr_cls)
  );

  logic                   active_q, active_d;
  region_e                cur_q, cur_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   wr_en_q, wr_en_d, wr_load;
  region_e                wr_region_q, wr_region_d;
  logic [ADDR_W-1:0]      wr_addr_q, wr_addr_d;
  logic [DATA_W-1:0]      wr_data_q;
  logic [NUM_REGIONS-1:0] irq_q, irq_d, irq_set;
  logic                   ovf_q, ovf_d, ovf_set;
  logic                   unexp_q, unexp_d, unexp_set;

  always_comb begin
    active_d    = active_q;
    cur_d       = cur_q;
    cnt_d       = cnt_q;
    wr_en_d     = 1'b0;
    wr_load     = 1'b0;
    wr_region_d = wr_region_q;
    wr_addr_d   = wr_addr_q;
    irq_set     = '0;
    ovf_set     = 1'b0;
    unexp_set   = 1'b0;
    if (hdr_valid) begin
      cur_d     = hdr_cls;
      cnt_d     = '0;
      active_d  = (hdr_cls != RG_DROP) && !hdr_empty;
      unexp_set = miss;
      if (hdr_cls != RG_DROP && hdr_empty) irq_set[hdr_cls] = 1'b1;
    end else if (active_q && pl_valid) begin
      if (cnt_q < cap_of(cur_q)) begin
        wr_en_d     = 1'b1;
        wr_load     = 1'b1;
        wr_region_d = cur_q;
        wr_addr_d   = cnt_q[ADDR_W-1:0];
        cnt_d       = cnt_q + 1'b1;
      end else begin
        ovf_set = 1'b1;
      end
      if (pl_last) begin
        active_d         = 1'b0;
        irq_set[cur_q]   = 1'b1;
      end
    end
    irq_d   = (irq_q & ~irq_clr) | irq_set;
    ovf_d   = (ovf_q & ~flag_clr[0]) | ovf_set;
    unexp_d = (unexp_q & ~flag_clr[1]) | unexp_set;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      active_q    <= 1'b0;
      cur_q       <= RG_GEN;
      cnt_q       <= '0;
      wr_en_q     <= 1'b0;
      wr_region_q <= RG_MAGT;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
      irq_q       <= '0;
      ovf_q       <= 1'b0;
      unexp_q     <= 1'b0;
    end else begin
      active_q    <= active_d;
      cur_q       <= cur_d;
      cnt_q       <= cnt_d;
      wr_en_q     <= wr_en_d;
      wr_region_q <= wr_region_d;
      wr_addr_q   <= wr_addr_d;
      if (wr_load) wr_data_q <= pl_data;
      irq_q       <= irq_d;
      ovf_q       <= ovf_d;
      unexp_q     <= unexp_d;
    end
  end

  assign wr_en      = wr_en_q;
  assign wr_region  = wr_region_q;
  assign wr_addr    = wr_addr_q;
  assign wr_data    = wr_data_q;
  assign irq        = irq_q;
  assign ovf_flag   = ovf_q;
  assign unexp_flag = unexp_q;
endmodule

// File: rtl/rps_checker.sv
module rps_checker
  import rps_pkg::*;
#(
  parameter int AGT_QUADS  = 2,
  parameter int ORB_QUADS  = 8,
  parameter int PTE_QUADS  = 2,
  parameter int GEN_QUADS  = 8,
  parameter int BULK_QUADS = 1024
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          hdr_valid,
  input logic [3:0]                    hdr_tcode,
  input logic                          wr_en,
  input logic [2:0]                    wr_region,
  input logic [$clog2(BULK_QUADS)-1:0] wr_addr,
  input logic [NUM_REGIONS-1:0]        irq,
  input logic [NUM_REGIONS-1:0]        irq_clr,
  input region_e                       cur_cls,
  input logic                          active
);
  function automatic int cap_chk(logic [2:0] r);
    case (r)
      3'd0, 3'd1: cap_chk = AGT_QUADS;
      3'd2, 3'd3: cap_chk = ORB_QUADS;
      3'd4:       cap_chk = PTE_QUADS;
      3'd5:       cap_chk = GEN_QUADS;
      3'd6:       cap_chk = BULK_QUADS;
      default:    cap_chk = 0;
    endcase
  endfunction

  AST_WR_REGION_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_region != 3'd7)); // R1
  AST_WR_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < cap_chk(wr_region))); // R2
  AST_RESP_NOT_GENERAL: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_tcode[3:1] == 3'b011) |=> (cur_cls != RG_GEN)); // R5
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !wr_en); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq) & ~$past(irq_clr) & ~irq) == '0)); // R9
endmodule

bind rx_payload_sorter rps_checker #(
  .AGT_QUADS(AGT_QUADS), .ORB_QUADS(ORB_QUADS), .PTE_QUADS(PTE_QUADS),
  .GEN_QUADS(GEN_QUADS), .BULK_QUADS(BULK_QUADS)
) u_rps_checker (
  .clk(clk), .rst_n(rst_s_n), .hdr_valid(hdr_valid), .hdr_tcode(hdr_tcode),
  .wr_en(wr_en), .wr_region(wr_region), .wr_addr(wr_addr),
  .irq(irq), .irq_clr(irq_clr), .cur_cls(cur_q), .active(active_q)
);

// File: tb/rx_payload_sorter_bench.sv
module rx_payload_sorter_bench;
  localparam logic [47:0] MGMT = 48'hFFFF_F001_0000;
  localparam logic [47:0] CMDO = 48'hFFFF_F001_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_issue = 0;
  logic [5:0]  req_label = 0;
  logic [1:0]  req_kind = 0;
  logic        hdr_valid = 0;
  logic [3:0]  hdr_tcode = 0;
  logic [5:0]  hdr_label = 0;
  logic [47:0] hdr_offset = 0;
  logic        hdr_empty = 0;
  logic        pl_valid = 0;
  logic [31:0] pl_data = 0;
  logic        pl_last = 0;
  logic        wr_en;
  logic [2:0]  wr_region;
  logic [9:0]  wr_addr;
  logic [31:0] wr_data;
  logic [6:0]  irq;
  logic [6:0]  irq_clr = 0;
  logic        ovf_flag, unexp_flag;
  logic [1:0]  flag_clr = 0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct { int region; int addr; logic [31:0] data; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  rx_payload_sorter u_rx_payload_sorter (
    .clk(clk), .rst_n(rst_n), .req_issue(req_issue), .req_label(req_label), .req_kind(req_kind),
    .hdr_valid(hdr_valid), .hdr_tcode(hdr_tcode), .hdr_label(hdr_label), .hdr_offset(hdr_offset),
    .hdr_empty(hdr_empty), .pl_valid(pl_valid), .pl_data(pl_data), .pl_last(pl_last),
    .wr_en(wr_en), .wr_region(wr_region), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq(irq), .irq_clr(irq_clr), .ovf_flag(ovf_flag), .unexp_flag(unexp_flag), .flag_clr(flag_clr)
  );

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && wr_en) begin
      if (sb.size() == 0) begin
        check(0, "R5/R8", "write with none expected", wr_region, 7);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(wr_region == 3'(e.region), "R1", "write region", wr_region, e.region);
        check(wr_addr == 10'(e.addr), "R7", "write address", wr_addr, e.addr);
        check(wr_data == e.data, "R7", "write data", wr_data, e.data);
      end
    end
    if (cycles > 150000) begin
      check(0, "WDOG", "watchdog expired", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic issue(input int label, input int kind);
    @(negedge clk);
    req_issue = 1; req_label = 6'(label); req_kind = 2'(kind);
    @(negedge clk);
    req_issue = 0;
  endtask

  // region 7 means the packet is expected to be discarded
  task automatic send(input int tcode, input int label, input logic [47:0] ofs,
                      input int nbeats, input int region, input int cap);
    @(negedge clk);
    hdr_valid = 1; hdr_tcode = 4'(tcode); hdr_label = 6'(label);
    hdr_offset = ofs; hdr_empty = (nbeats == 0);
    for (int b = 0; b < nbeats; b++) begin
      @(negedge clk);
      hdr_valid = 0;
      pl_valid = 1; pl_last = (b == nbeats - 1);
      pl_data = 32'hC000_0000 | (32'(label) << 16) | 32'(b) | (32'(region) << 24);
      if (region != 7 && b < cap) sb.push_back('{region, b, pl_data});
    end
    @(negedge clk);
    hdr_valid = 0; pl_valid = 0; pl_last = 0;
    @(negedge clk);
    check(sb.size() == 0, "R7", "pending writes after packet", sb.size(), 0);
  endtask

  task automatic clear_all;
    @(negedge clk); irq_clr = 7'h7f; flag_clr = 2'b11;
    @(negedge clk); irq_clr = 0; flag_clr = 0;
    check(irq == 0, "R9", "irq after write-1 clear", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(irq == 0 && !ovf_flag && !unexp_flag && !wr_en, "R11", "reset outputs",
          {irq, ovf_flag, unexp_flag, wr_en}, 0);

    // R11 no label outstanding after reset: response to label 7 is dropped
    send(7, 7, 0, 2, 7, 0);
    check(unexp_flag == 1, "R11", "unexp after reset response", unexp_flag, 1);
    check(irq == 0, "R5", "no irq for dropped response", irq, 0);
    clear_all();

    // R3 agent pointer writes by offset
    send(1, 1, MGMT, 2, 0, 2);
    check(irq == 7'h01, "R3", "irq mgmt agent", irq, 1);
    clear_all();
    send(0, 2, CMDO, 1, 1, 2);
    check(irq == 7'h02, "R3", "irq cmd agent", irq, 2);
    clear_all();
    send(1, 3, 48'hFFFF_F000_0400, 3, 5, 8);
    check(irq == 7'h20, "R3", "irq general write", irq, 7'h20);
    clear_all();

    // R4 label-matched responses by recorded kind
    issue(5, 0);
    send(7, 5, 0, 8, 2, 8);
    check(irq == 7'h04, "R4", "irq mgmt block", irq, 4);
    issue(9, 1);
    send(7, 9, 0, 8, 3, 8);
    check(irq == 7'h0c, "R4", "irq cmd block accumulates", irq, 7'h0c);
    clear_all();
    issue(12, 2);
    send(6, 12, 0, 2, 4, 2);
    check(irq == 7'h10, "R4", "irq page table", irq, 7'h10);
    clear_all();
    issue(33, 3);
    send(7, 33, 0, 20, 6, 1024);
    check(irq == 7'h40, "R4", "irq bulk", irq, 7'h40);
    check(ovf_flag == 0, "R8", "no overflow under capacity", ovf_flag, 0);
    clear_all();

    // R5 consumed label now unmatched
    send(7, 5, 0, 3, 7, 0);
    check(unexp_flag == 1, "R5", "unexp on consumed label", unexp_flag, 1);
    check(irq == 0, "R5", "no irq for drop", irq, 0);

    // R10 flag clear
    @(negedge clk); flag_clr = 2'b10;
    @(negedge clk); flag_clr = 0;
    check(unexp_flag == 0, "R10", "unexp cleared", unexp_flag, 0);

    // R6 read request without payload
    send(4, 20, 48'hFFFF_F000_0400, 0, 5, 8);
    check(irq == 7'h20, "R6", "read request to general", irq, 7'h20);
    // R9 sticky over idle cycles
    repeat (5) @(negedge clk);
    check(irq == 7'h20, "R9", "irq holds", irq, 7'h20);
    clear_all();

    // R8 overflow on a command block
    issue(40, 1);
    send(7, 40, 0, 10, 3, 8);
    check(ovf_flag == 1, "R8", "overflow set", ovf_flag, 1);
    check(irq == 7'h08, "R8", "irq after truncated packet", irq, 8);
    @(negedge clk); flag_clr = 2'b01;
    @(negedge clk); flag_clr = 0;
    check(ovf_flag == 0, "R10", "ovf cleared", ovf_flag, 0);
    clear_all();

    // R2 bulk capacity boundary
    issue(41, 3);
    send(7, 41, 0, 1030, 6, 1024);
    check(ovf_flag == 1, "R2", "bulk capped at 1024", ovf_flag, 1);
    check(irq == 7'h40, "R2", "irq bulk boundary", irq, 7'h40);
    clear_all();

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R7", "scoreboard empty at end", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule